// File: doc/BRIEF.md
# Priority-Sorting Crossbar Routing Module

This block serves one output group of a two-stage cell switch. Each of its N rows carries the cell stream of one input controller. Each of its LxM columns ends in one output line toward the group. Each crosspoint of the grid compares the cell arriving from the west with the cell arriving from the north. It either passes both straight on (across) or swaps them (toggle). The swap happens when the two cells carry the same destination and the west cell has the strictly higher priority. A column-top broadcaster feeds every column with an empty placeholder that carries the group address at priority zero. The grid therefore works as an insertion sorter: the LxM highest-priority matching cells reach the columns in descending order, and every losing cell leaves on a row's right edge.

A cell time is one header word followed by CELL_LEN-1 body words. A small sequencer has two states. In ST_IDLE the grid routes with live decisions. The transition IDLE_TO_BODY is taken when `cell_start` is high. At that edge every crosspoint state is latched, and a per-input rejection vector is registered from the cells leaving the right edges, each tagged with its source row. In ST_BODY the latched states steer the body words, and `cell_start` is ignored. The transition BODY_TO_IDLE is taken after the last body word.

A word has these fields: bit W-1 valid, bit W-2 group-member flag, bits [AW+PW-1:AW] priority (unsigned), bits [AW-1:0] destination address, with W = 2+PW+AW.

Top module: `prio_xbar_route`

## Requirements
- R1: After reset `fb_valid` and `rej` are 0, and with all-zero inputs every column outputs the placeholder word {valid=0, member=1, priority=0, destination=GROUP}.
- R2: A single valid member cell with destination GROUP and nonzero priority appears on column 0 in its header cycle, and its `rej` bit is 0.
- R3: When more matching cells arrive than there are columns, the columns carry the highest-priority cells in descending priority from column 0 upward.
- R4: One cycle after the header edge, `fb_valid` is high for exactly one cycle and `rej` has a 1 for each valid matching input that did not reach a column.
- R5: A tie in priority keeps the across state, so among equal priorities the lower row index takes the lower column, and the higher row index is rejected on overflow.
- R6: A cell whose member bit is clear reaches no column and is not flagged as rejected.
- R7: A cell whose destination differs from GROUP reaches no column and is not flagged as rejected.
- R8: A valid matching cell of priority 0 never displaces a placeholder and is flagged as rejected.
- R9: Each of the CELL_LEN-1 body words following a header leaves on the column its header won, whatever the body word contents.
- R10: A `cell_start` during the body cycles has no effect: routing stays latched, `fb_valid` stays 0 and `rej` is unchanged.
- R11: Every valid cell entering leaves exactly once, either on a column or on a right edge.
- R12: A column that no cell wins carries the placeholder word, for the header and the body words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_start | input | 1 | Marks the header word of a new cell time |
| row_word | input | N_IN*W | One word per input row, row r in bits [r*W +: W] |
| col_word | output | LM*W | One word per column bottom, column c in bits [c*W +: W] |
| fb_valid | output | 1 | One-cycle pulse: `rej` was just updated |
| rej | output | N_IN | Per-input rejection flags, held for the cell time |

## Verification
Column outputs are combinational through the grid, so they are due in the same cycle their words are driven. The bench samples them two time units after the negedge that drives the inputs. `fb_valid` and `rej` are registered at the header edge and are due one cycle later, so they are sampled one time unit after that posedge. Body words follow at the next CELL_LEN-1 negedges. At each of them the bench checks the columns against the winners of the header, and after each body edge it checks that `fb_valid` stays low and `rej` keeps its value, including when a stray `cell_start` is driven.

// File: rtl/prsw_pkg.sv
package prsw_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BODY = 1'b1
    } seq_state_e;
endpackage

// File: rtl/xp_cell.sv
module xp_cell #(
    parameter int PW = 3,
    parameter int AW = 4,
    parameter int SW = 2,
    localparam int W = 2 + PW + AW
) (
    input  logic [W-1:0]  n_word,
    input  logic [SW-1:0] n_src,
    input  logic [W-1:0]  w_word,
    input  logic [SW-1:0] w_src,
    input  logic          hold,
    input  logic          held_tog,
    output logic [W-1:0]  s_word,
    output logic [SW-1:0] s_src,
    output logic [W-1:0]  e_word,
    output logic [SW-1:0] e_src,
    output logic          live_tog
);
    logic addr_hit;
    logic prio_win;
    logic use_tog;

    always_comb begin
        addr_hit = w_word[W-1] && w_word[W-2] && (w_word[AW-1:0] == n_word[AW-1:0]);
        prio_win = w_word[AW+PW-1:AW] > n_word[AW+PW-1:AW];
        live_tog = addr_hit && prio_win;
        use_tog  = hold ? held_tog : live_tog;
        s_word   = use_tog ? w_word : n_word;
        s_src    = use_tog ? w_src  : n_src;
        e_word   = use_tog ? n_word : w_word;
        e_src    = use_tog ? n_src  : w_src;
    end
endmodule

// File: rtl/xp_grid.sv
module xp_grid #(
    parameter int N     = 4,
    parameter int LM    = 2,
    parameter int PW    = 3,
    parameter int AW    = 4,
    parameter int SW    = 2,
    parameter int GROUP = 5,
    localparam int W = 2 + PW + AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic            capture,
    input  logic [N*W-1:0]  row_word,
    output logic [LM*W-1:0] col_word,
    output logic [N*W-1:0]  exit_word,
    output logic [N*SW-1:0] exit_src
);
    localparam logic [W-1:0] PLACEHOLDER = {1'b0, 1'b1, {PW{1'b0}}, AW'(GROUP)};

    logic [W-1:0]  vw [0:N][0:LM-1];
    logic [SW-1:0] vs [0:N][0:LM-1];
    logic [W-1:0]  hw [0:N-1][0:LM];
    logic [SW-1:0] hs [0:N-1][0:LM];
    logic [N-1:0][LM-1:0] live_tog;
    logic [N-1:0][LM-1:0] tog_q;
    logic [N-1:0]  in_v;
    logic [N-1:0]  ex_v;
    logic [LM-1:0] out_v;

    always_ff @(posedge clk) begin
        if (!rst_n)       tog_q <= '0;
        else if (capture) tog_q <= live_tog;
    end

    for (genvar c = 0; c < LM; c++) begin : g_col
        assign vw[0][c] = PLACEHOLDER;
        assign vs[0][c] = '0;
        assign col_word[c*W +: W] = vw[N][c];
        assign out_v[c] = vw[N][c][W-1];
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        assign hw[r][0] = row_word[r*W +: W];
        assign hs[r][0] = SW'(r);
        assign exit_word[r*W +: W]   = hw[r][LM];
        assign exit_src[r*SW +: SW]  = hs[r][LM];
        assign in_v[r] = row_word[r*W + W - 1];
        assign ex_v[r] = hw[r][LM][W-1];
        for (genvar c = 0; c < LM; c++) begin : g_xp
            xp_cell #(.PW(PW), .AW(AW), .SW(SW)) u_xp (
                .n_word   (vw[r][c]),
                .n_src    (vs[r][c]),
                .w_word   (hw[r][c]),
                .w_src    (hs[r][c]),
                .hold     (hold),
                .held_tog (tog_q[r][c]),
                .s_word   (vw[r+1][c]),
                .s_src    (vs[r+1][c]),
                .e_word   (hw[r][c+1]),
                .e_src    (hs[r][c+1]),
                .live_tog (live_tog[r][c])
            );
        end
    end

    // R11: valid cells are neither created nor dropped inside the grid
    p_conserve_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_v) == $countones(out_v) + $countones(ex_v));

    for (genvar c = 0; c + 1 < LM; c++) begin : g_ord
        // R3: columns leave the live sort in descending priority
        p_col_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !hold |-> (vw[N][c][AW+PW-1:AW] >= vw[N][c+1][AW+PW-1:AW]));
    end
endmodule

// File: rtl/cell_timer.sv
module cell_timer #(
    parameter int CELL_LEN = 4,
    localparam int CW = (CELL_LEN > 2) ? $clog2(CELL_LEN) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cell_start,
    output logic hold,
    output logic capture
);
    import prsw_pkg::*;

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hold    = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cell_start) begin
                    capture = 1'b1;
                    state_d = ST_BODY;
                    cnt_d   = '0;
                end
            end
            ST_BODY: begin
                hold = 1'b1;
                if (cnt_q == CW'(CELL_LEN - 2)) state_d = ST_IDLE;
                else                            cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R9: the body phase never runs past CELL_LEN-1 words
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BODY) |-> (cnt_q <= CW'(CELL_LEN - 2)));
endmodule

// File: rtl/prio_xbar_route.sv
module prio_xbar_route #(
    parameter int N_IN     = 4,
    parameter int EXP_L    = 1,
    parameter int GRP_M    = 2,
    parameter int PW       = 3,
    parameter int AW       = 4,
    parameter int GROUP    = 5,
    parameter int CELL_LEN = 4,
    localparam int LM = EXP_L * GRP_M,
    localparam int W  = 2 + PW + AW,
    localparam int SW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_start,
    input  logic [N_IN*W-1:0] row_word,
    output logic [LM*W-1:0]   col_word,
    output logic              fb_valid,
    output logic [N_IN-1:0]   rej
);
    logic hold;
    logic capture;
    logic [N_IN*W-1:0]  exit_word;
    logic [N_IN*SW-1:0] exit_src;
    logic [N_IN-1:0]    rej_d;

    cell_timer #(.CELL_LEN(CELL_LEN)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_start (cell_start),
        .hold       (hold),
        .capture    (capture)
    );

    xp_grid #(
        .N(N_IN), .LM(LM), .PW(PW), .AW(AW), .SW(SW), .GROUP(GROUP)
    ) u_grid (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .capture   (capture),
        .row_word  (row_word),
        .col_word  (col_word),
        .exit_word (exit_word),
        .exit_src  (exit_src)
    );

    always_comb begin
        rej_d = '0;
        for (int r = 0; r < N_IN; r++) begin
            if (exit_word[r*W + W - 1] && exit_word[r*W + W - 2] &&
                (exit_word[r*W +: AW] == AW'(GROUP)))
                rej_d[exit_src[r*SW +: SW]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rej      <= '0;
            fb_valid <= 1'b0;
        end else begin
            fb_valid <= capture;
            if (capture) rej <= rej_d;
        end
    end

    // R4: feedback strobe lasts a single cycle
    p_fb_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fb_valid |=> !fb_valid);
    // R10: rejection flags only move together with the strobe
    p_rej_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rej) |-> fb_valid);
endmodule

// File: tb/sim_prio_xbar_route.sv
module sim_prio_xbar_route;
    localparam int N  = 4;
    localparam int LM = 2;
    localparam int PW = 3;
    localparam int AW = 4;
    localparam int G  = 5;
    localparam int CL = 4;
    localparam int W  = 2 + PW + AW;
    localparam logic [W-1:0] PH = {1'b0, 1'b1, 3'd0, 4'(G)};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cell_start = 1'b0;
    logic [N*W-1:0]  row_word = '0;
    logic [LM*W-1:0] col_word;
    logic fb_valid;
    logic [N-1:0] rej;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    prio_xbar_route #(.N_IN(N), .EXP_L(1), .GRP_M(LM), .PW(PW), .AW(AW),
                      .GROUP(G), .CELL_LEN(CL)) u0 (
        .clk(clk), .rst_n(rst_n), .cell_start(cell_start), .row_word(row_word),
        .col_word(col_word), .fb_valid(fb_valid), .rej(rej));

    function automatic logic [W-1:0] hdr(input bit v, input bit m, input int p, input int d);
        return {v, m, 3'(p), 4'(d)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one full cell time; stray=1 raises cell_start in the first body cycle (R10)
    task automatic run_cell(input string tag, input logic [W-1:0] h [N], input bit stray);
        int win [LM];
        logic [N-1:0] erej;
        bit taken [N];
        logic [W-1:0] b [N];
        erej = '0;
        for (int r = 0; r < N; r++) taken[r] = 0;
        for (int c = 0; c < LM; c++) begin
            int best;
            best = -1;
            for (int r = 0; r < N; r++) begin
                if (!taken[r] && h[r][W-1] && h[r][W-2] && h[r][AW-1:0] == 4'(G) &&
                    h[r][AW+PW-1:AW] != 0) begin
                    if (best < 0 || h[r][AW+PW-1:AW] > h[best][AW+PW-1:AW]) best = r;
                end
            end
            win[c] = best;
            if (best >= 0) taken[best] = 1;
        end
        for (int r = 0; r < N; r++)
            if (!taken[r] && h[r][W-1] && h[r][W-2] && h[r][AW-1:0] == 4'(G)) erej[r] = 1'b1;
        // header cycle
        @(negedge clk);
        cell_start = 1'b1;
        for (int r = 0; r < N; r++) row_word[r*W +: W] = h[r];
        #2;
        for (int c = 0; c < LM; c++)
            chk({tag, " R3 R12 header column"}, 32'(col_word[c*W +: W]),
                32'(win[c] >= 0 ? h[win[c]] : PH));
        @(posedge clk); #1;
        chk({tag, " R4 fb_valid pulse"}, 32'(fb_valid), 32'd1);
        chk({tag, " R4 rej vector"}, 32'(rej), 32'(erej));
        // body cycles: words whose own contents would sort row 0 first (R9)
        for (int k = 1; k < CL; k++) begin
            @(negedge clk);
            cell_start = (stray && k == 1);
            for (int r = 0; r < N; r++) begin
                b[r] = hdr(1, 1, 7 - r - k + 1, G);
                row_word[r*W +: W] = b[r];
            end
            #2;
            for (int c = 0; c < LM; c++)
                chk({tag, " R9 body column"}, 32'(col_word[c*W +: W]),
                    32'(win[c] >= 0 ? b[win[c]] : PH));
            @(posedge clk); #1;
            chk({tag, " R10 no strobe in body"}, 32'(fb_valid), 32'd0);
            chk({tag, " R10 rej held"}, 32'(rej), 32'(erej));
        end
        @(negedge clk);
        cell_start = 1'b0;
        row_word = '0;
    endtask

    task automatic t_reset();
        #2;
        chk("R1 fb_valid reset", 32'(fb_valid), 32'd0);
        chk("R1 rej reset", 32'(rej), 32'd0);
        for (int c = 0; c < LM; c++)
            chk("R1 R12 placeholder", 32'(col_word[c*W +: W]), 32'(PH));
    endtask

    task automatic t_single();
        logic [W-1:0] h [N];
        h[0] = '0; h[1] = '0; h[2] = hdr(1, 1, 3, G); h[3] = '0;
        run_cell("R2 single", h, 0);
    endtask

    task automatic t_overflow();
        logic [W-1:0] h [N];
        h[0] = hdr(1, 1, 2, G); h[1] = hdr(1, 1, 5, G);
        h[2] = hdr(1, 1, 7, G); h[3] = hdr(1, 1, 1, G);
        run_cell("R3 R11 overflow", h, 0);
    endtask

    task automatic t_ties();
        logic [W-1:0] h [N];
        for (int r = 0; r < N; r++) h[r] = hdr(1, 1, 4, G);
        run_cell("R5 ties", h, 0);
    endtask

    task automatic t_nonmatch();
        logic [W-1:0] h [N];
        h[0] = hdr(1, 0, 7, G);   // R6
        h[1] = hdr(1, 1, 7, 3);   // R7
        h[2] = hdr(1, 1, 2, G);
        h[3] = hdr(1, 1, 0, G);   // R8
        run_cell("R6 R7 R8 nonmatch", h, 0);
    endtask

    task automatic t_stray();
        logic [W-1:0] h [N];
        h[0] = hdr(1, 1, 1, G); h[1] = hdr(1, 1, 6, G);
        h[2] = hdr(1, 1, 3, G); h[3] = hdr(1, 1, 6, G);
        run_cell("R10 stray start", h, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_overflow();
        t_ties();
        t_nonmatch();
        t_stray();
        t_single();
        done = 1'b1;
    end

    initial begin
        fork
            begin : wd
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
            wait (done);
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule